// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block makes the handshake decision for the general-purpose endpoints of a USB device function. It keeps a small control register, an interrupt status register and an interrupt mask for each endpoint. When the packet engine finishes decoding a transaction, it presents one strobe. That strobe carries the endpoint number, the direction, the FIFO fill level (bytes held for IN, free bytes for OUT), the packet length, the maximum packet size, the received data toggle and an error flag. One cycle later the block answers with ACK, NAK, STALL or no response. It also gives the number of bytes to send for IN, whether OUT data is kept, and the toggle to use. At the same clock edge it updates that endpoint's toggle, control and status bits.

Firmware reaches the registers through a flat register port. Each endpoint gets four byte-wide slots at address `{endpoint, select}`. Select 0 is control, 1 is status and 2 is mask. Reads are combinational. The control register has these bits:

| Bit | Function | Access |
|---|---|---|
| 0 | forced NAK | read/write |
| 1 | forced STALL | read/write |
| 2 | automatic forced NAK | read/write |
| 3 | short IN enable | read/write |
| 4 | short OUT override | read/write |
| 5 | toggle | read only |
| 6 | toggle set | write-one strobe |
| 7 | toggle clear | write-one strobe |

The status and mask registers share one layout:

| Bit | Event |
|---|---|
| 0 | IN ACK |
| 1 | OUT ACK |
| 2 | OUT short ACK |
| 3 | IN NAK |
| 4 | OUT NAK |
| 5 | IN error |
| 6 | OUT error |

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: After reset, every control, status and mask register reads 0, the toggle is 0, `hs_valid` is 0 and every `irq` bit is 0.
- R2: For an error-free transaction on an endpoint with forced STALL set, the response is STALL (code 3), even if forced NAK is also set. No status bit is set.
- R3: For an error-free transaction with forced NAK set and forced STALL clear, the response is NAK (code 2), whatever the FIFO level. IN NAK (bit 3) or OUT NAK (bit 4) is set.
- R4: Without forcing, an OUT transaction behaves as follows. If the free space is below the packet length, the response is NAK and OUT NAK is set. Otherwise it is ACK (code 1). OUT short ACK (bit 2) is set when the length is below the maximum packet size, and OUT ACK (bit 1) is set otherwise.
- R5: Without forcing, an IN transaction behaves as follows. If at least the maximum packet size is buffered, the response is ACK with `hs_len` equal to the maximum. If less is buffered and short IN enable is set, the response is ACK with `hs_len` equal to the buffered count, and short IN enable clears itself. If less is buffered and short IN enable is clear, the response is NAK. Each ACK sets IN ACK (bit 0).
- R6: An ACKed IN flips the toggle, and `hs_tgl` reports the toggle that was used. For an ACKed OUT, a matching received toggle flips it and gives `hs_keep`=1. A mismatching one leaves the toggle unchanged and gives `hs_keep`=0.
- R7: Writing 1 to control bit 6 sets the toggle, and writing 1 to bit 7 clears it. Bit 5 reads the toggle back.
- R8: With automatic forced NAK set, every ACKed OUT transaction sets forced NAK.
- R9: With automatic forced NAK and short OUT override both set, an ACKed short OUT does not set forced NAK.
- R10: A transaction flagged as an error gets no response (code 0). It sets IN error (bit 5) or OUT error (bit 6), and it changes no toggle or control bit. An error takes precedence over STALL.
- R11: Status bits are write-one-to-clear. A hardware set in the same cycle as a clear of that bit wins.
- R12: `irq[e]` is the OR of endpoint e's status bits, each ANDed with its mask bit.
- R13: `hs_valid` pulses exactly one cycle after `txn_end`. Only the addressed endpoint's registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | EP_W+2 | {endpoint, select} register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| txn_end | input | 1 | Decoded transaction strobe |
| txn_ep | input | EP_W | Endpoint addressed |
| txn_in | input | 1 | 1 = IN, 0 = OUT |
| fifo_lvl | input | CNT_W | Bytes buffered (IN) or free (OUT) |
| pkt_len | input | CNT_W | Received OUT packet length |
| max_pkt | input | CNT_W | Endpoint maximum packet size |
| pkt_tgl | input | 1 | Received data toggle (OUT) |
| txn_err | input | 1 | Transaction error |
| hs_valid | output | 1 | Handshake result valid |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| hs_len | output | CNT_W | Bytes to send on an ACKed IN |
| hs_keep | output | 1 | ACKed OUT data is kept |
| hs_tgl | output | 1 | Toggle used for the transaction |
| irq | output | NUM_EP | Per-endpoint masked interrupt |

## Verification
The toggle and short-enable assertions assume firmware does not write a control register in the same cycle that a transaction strikes that endpoint. Each of these properties is qualified by the absence of such a write. The only deliberate collision the bench drives is a status clear against a status set. The assertions also assume `txn_ep` names an existing endpoint. The bench only addresses endpoints 0 to 3 and applies each strobe for exactly one cycle, with its fields held steady for that cycle.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_code_e;

    // control bits 4..0
    typedef struct packed {
        logic short_ovr;
        logic short_en;
        logic auto_fnak;
        logic force_stall;
        logic force_nak;
    } ep_ctrl_t;

    // status / mask bits 6..0
    typedef struct packed {
        logic out_err;
        logic in_err;
        logic out_nak;
        logic in_nak;
        logic out_short;
        logic out_ack;
        logic in_ack;
    } ep_stat_t;

    localparam int CTRL_W      = $bits(ep_ctrl_t);
    localparam int STAT_W      = $bits(ep_stat_t);
    localparam int TGL_SET_BIT = 6;
    localparam int TGL_CLR_BIT = 7;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_MASK = 2'd2;

    function automatic logic [7:0] pack_ctrl(ep_ctrl_t c, logic tgl);
        return {2'b00, tgl, c};
    endfunction

endpackage

// File: rtl/usb_hs_decide.sv
module usb_hs_decide
    import usb_hs_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  ep_ctrl_t           ctrl,
    input  logic               tgl,
    input  logic               dir_in,
    input  logic [CNT_W-1:0]   fifo_lvl,
    input  logic [CNT_W-1:0]   pkt_len,
    input  logic [CNT_W-1:0]   max_pkt,
    input  logic               pkt_tgl,
    input  logic               err,
    output hs_code_e           code,
    output logic               keep,
    output logic [CNT_W-1:0]   send_len,
    output ep_stat_t           set_stat,
    output logic               flip,
    output logic               short_used,
    output logic               auto_set
);
    logic out_short;
    assign out_short = pkt_len < max_pkt;

    always_comb begin
        code       = HS_NONE;
        keep       = 1'b0;
        send_len   = '0;
        set_stat   = '0;
        flip       = 1'b0;
        short_used = 1'b0;
        auto_set   = 1'b0;
        if (err) begin
            if (dir_in) set_stat.in_err  = 1'b1;
            else        set_stat.out_err = 1'b1;
        end else if (ctrl.force_stall) begin
            code = HS_STALL;
        end else if (ctrl.force_nak) begin
            code = HS_NAK;
            if (dir_in) set_stat.in_nak  = 1'b1;
            else        set_stat.out_nak = 1'b1;
        end else if (dir_in) begin
            if (fifo_lvl >= max_pkt) begin
                code            = HS_ACK;
                send_len        = max_pkt;
                flip            = 1'b1;
                set_stat.in_ack = 1'b1;
            end else if (ctrl.short_en) begin
                code            = HS_ACK;
                send_len        = fifo_lvl;
                flip            = 1'b1;
                short_used      = 1'b1;
                set_stat.in_ack = 1'b1;
            end else begin
                code            = HS_NAK;
                set_stat.in_nak = 1'b1;
            end
        end else begin
            if (fifo_lvl < pkt_len) begin
                code             = HS_NAK;
                set_stat.out_nak = 1'b1;
            end else begin
                code               = HS_ACK;
                keep               = (pkt_tgl == tgl);
                flip               = keep;
                set_stat.out_short = out_short;
                set_stat.out_ack   = !out_short;
                auto_set           = ctrl.auto_fnak && !(out_short && ctrl.short_ovr);
            end
        end
    end

endmodule

// File: rtl/usb_ep_state.sv
module usb_ep_state
    import usb_hs_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_stat,
    input  logic             wr_mask,
    input  logic [7:0]       wdata,
    input  logic             hit,
    input  logic             dir_in,
    input  logic [CNT_W-1:0] fifo_lvl,
    input  logic [CNT_W-1:0] pkt_len,
    input  logic [CNT_W-1:0] max_pkt,
    input  logic             pkt_tgl,
    input  logic             err,
    output ep_ctrl_t         ctrl_q,
    output logic             tgl_q,
    output ep_stat_t         stat_q,
    output ep_stat_t         mask_q,
    output logic             irq,
    output hs_code_e         code,
    output logic             keep,
    output logic [CNT_W-1:0] send_len
);
    ep_stat_t set_stat;
    logic     flip, short_used, auto_set;
    ep_ctrl_t ctrl_d;
    logic     tgl_d;
    ep_stat_t stat_d;

    usb_hs_decide #(.CNT_W(CNT_W)) u_decide (
        .ctrl      (ctrl_q),
        .tgl       (tgl_q),
        .dir_in    (dir_in),
        .fifo_lvl  (fifo_lvl),
        .pkt_len   (pkt_len),
        .max_pkt   (max_pkt),
        .pkt_tgl   (pkt_tgl),
        .err       (err),
        .code      (code),
        .keep      (keep),
        .send_len  (send_len),
        .set_stat  (set_stat),
        .flip      (flip),
        .short_used(short_used),
        .auto_set  (auto_set)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) ctrl_d = ep_ctrl_t'(wdata[CTRL_W-1:0]);
        if (hit && auto_set)   ctrl_d.force_nak = 1'b1;
        if (hit && short_used) ctrl_d.short_en  = 1'b0;

        tgl_d = tgl_q;
        if (wr_ctrl && wdata[TGL_SET_BIT]) tgl_d = 1'b1;
        if (wr_ctrl && wdata[TGL_CLR_BIT]) tgl_d = 1'b0;
        if (hit && flip) tgl_d = !tgl_q;

        stat_d = stat_q;
        if (wr_stat) stat_d = stat_d & ~ep_stat_t'(wdata[STAT_W-1:0]);
        if (hit)     stat_d = stat_d | set_stat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tgl_q  <= 1'b0;
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            tgl_q  <= tgl_d;
            stat_q <= stat_d;
            if (wr_mask) mask_q <= ep_stat_t'(wdata[STAT_W-1:0]);
        end
    end

    assign irq = |(stat_q & mask_q);

    p_stall_wins_r2: assert property (@(posedge clk) disable iff (rst)
        hit && !err && ctrl_q.force_stall |-> code == HS_STALL);

    p_force_nak_r3: assert property (@(posedge clk) disable iff (rst)
        hit && !err && !ctrl_q.force_stall && ctrl_q.force_nak |-> code == HS_NAK);

    p_short_clear_r5: assert property (@(posedge clk) disable iff (rst)
        hit && dir_in && code == HS_ACK && send_len < max_pkt && !wr_ctrl
        |=> !ctrl_q.short_en);

    p_toggle_flip_r6: assert property (@(posedge clk) disable iff (rst)
        hit && code == HS_ACK && (dir_in || keep) && !wr_ctrl
        |=> tgl_q != $past(tgl_q));

    p_auto_fnak_r8: assert property (@(posedge clk) disable iff (rst)
        hit && !dir_in && code == HS_ACK && ctrl_q.auto_fnak
        && !(pkt_len < max_pkt && ctrl_q.short_ovr) |=> ctrl_q.force_nak);

    p_err_silent_r10: assert property (@(posedge clk) disable iff (rst)
        hit && err && !wr_ctrl |-> code == HS_NONE ##1 $stable(tgl_q) && $stable(ctrl_q));

endmodule

// File: rtl/usb_ep_hs_ctrl.sv
module usb_ep_hs_ctrl
    import usb_hs_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int CNT_W  = 11,
    localparam int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int ADDR_W = EP_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              txn_end,
    input  logic [EP_W-1:0]   txn_ep,
    input  logic              txn_in,
    input  logic [CNT_W-1:0]  fifo_lvl,
    input  logic [CNT_W-1:0]  pkt_len,
    input  logic [CNT_W-1:0]  max_pkt,
    input  logic              pkt_tgl,
    input  logic              txn_err,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic [CNT_W-1:0]  hs_len,
    output logic              hs_keep,
    output logic              hs_tgl,
    output logic [NUM_EP-1:0] irq
);
    logic [EP_W-1:0] reg_ep;
    logic [1:0]      reg_sel;
    assign reg_ep  = reg_addr[ADDR_W-1:2];
    assign reg_sel = reg_addr[1:0];

    ep_ctrl_t         ep_ctrl [NUM_EP];
    logic             ep_tgl  [NUM_EP];
    ep_stat_t         ep_stat [NUM_EP];
    ep_stat_t         ep_mask [NUM_EP];
    hs_code_e         ep_code [NUM_EP];
    logic             ep_keep [NUM_EP];
    logic [CNT_W-1:0] ep_len  [NUM_EP];

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        logic sel_me;
        assign sel_me = reg_wr && (reg_ep == EP_W'(e));

        usb_ep_state #(.CNT_W(CNT_W)) u_ep (
            .clk     (clk),
            .rst     (rst),
            .wr_ctrl (sel_me && reg_sel == SEL_CTRL),
            .wr_stat (sel_me && reg_sel == SEL_STAT),
            .wr_mask (sel_me && reg_sel == SEL_MASK),
            .wdata   (reg_wdata),
            .hit     (txn_end && txn_ep == EP_W'(e)),
            .dir_in  (txn_in),
            .fifo_lvl(fifo_lvl),
            .pkt_len (pkt_len),
            .max_pkt (max_pkt),
            .pkt_tgl (pkt_tgl),
            .err     (txn_err),
            .ctrl_q  (ep_ctrl[e]),
            .tgl_q   (ep_tgl[e]),
            .stat_q  (ep_stat[e]),
            .mask_q  (ep_mask[e]),
            .irq     (irq[e]),
            .code    (ep_code[e]),
            .keep    (ep_keep[e]),
            .send_len(ep_len[e])
        );
    end

    always_comb begin
        reg_rdata = 8'h00;
        for (int e = 0; e < NUM_EP; e++) begin
            if (reg_ep == EP_W'(e)) begin
                case (reg_sel)
                    SEL_CTRL: reg_rdata = pack_ctrl(ep_ctrl[e], ep_tgl[e]);
                    SEL_STAT: reg_rdata = 8'(ep_stat[e]);
                    SEL_MASK: reg_rdata = 8'(ep_mask[e]);
                    default:  reg_rdata = 8'h00;
                endcase
            end
        end
    end

    hs_code_e code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_valid <= 1'b0;
            code_q   <= HS_NONE;
            hs_len   <= '0;
            hs_keep  <= 1'b0;
            hs_tgl   <= 1'b0;
        end else begin
            hs_valid <= txn_end;
            if (txn_end) begin
                code_q  <= ep_code[txn_ep];
                hs_len  <= ep_len[txn_ep];
                hs_keep <= ep_keep[txn_ep];
                hs_tgl  <= ep_tgl[txn_ep];
            end
        end
    end

    assign hs_code = code_q;

    p_valid_follows_r13: assert property (@(posedge clk) disable iff (rst)
        txn_end |=> hs_valid);

    p_valid_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        !txn_end |=> !hs_valid);

endmodule

// File: tb/tb_usb_ep_hs_ctrl.sv
module tb_usb_ep_hs_ctrl;
    localparam int NUM_EP = 4;
    localparam int CNT_W  = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [3:0]       reg_addr = '0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             txn_end = 1'b0;
    logic [1:0]       txn_ep = '0;
    logic             txn_in = 1'b0;
    logic [CNT_W-1:0] fifo_lvl = '0;
    logic [CNT_W-1:0] pkt_len = '0;
    logic [CNT_W-1:0] max_pkt = '0;
    logic             pkt_tgl = 1'b0;
    logic             txn_err = 1'b0;
    logic             hs_valid;
    logic [1:0]       hs_code;
    logic [CNT_W-1:0] hs_len;
    logic             hs_keep;
    logic             hs_tgl;
    logic [NUM_EP-1:0] irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    usb_ep_hs_ctrl #(.NUM_EP(NUM_EP), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txn_end(txn_end),
        .txn_ep(txn_ep), .txn_in(txn_in), .fifo_lvl(fifo_lvl),
        .pkt_len(pkt_len), .max_pkt(max_pkt), .pkt_tgl(pkt_tgl),
        .txn_err(txn_err), .hs_valid(hs_valid), .hs_code(hs_code),
        .hs_len(hs_len), .hs_keep(hs_keep), .hs_tgl(hs_tgl), .irq(irq)
    );

    localparam int ACK = 1, NAK = 2, STALL = 3, NONE = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = addr[3:0]; reg_wdata = data[7:0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, int addr, int exp);
        reg_addr = addr[3:0];
        #1;
        chk(req, int'(reg_rdata), exp);
    endtask

    task automatic txn(int ep, bit dir_in, int lvl, int len, int mx, bit tg, bit er);
        @(negedge clk);
        txn_end = 1'b1; txn_ep = ep[1:0]; txn_in = dir_in;
        fifo_lvl = lvl[CNT_W-1:0]; pkt_len = len[CNT_W-1:0];
        max_pkt = mx[CNT_W-1:0]; pkt_tgl = tg; txn_err = er;
        @(negedge clk);
        txn_end = 1'b0; txn_err = 1'b0;
    endtask

    task automatic t_reset;
        for (int e = 0; e < NUM_EP; e++) begin
            rd_chk("R1 ctrl", e*4 + 0, 0);
            rd_chk("R1 stat", e*4 + 1, 0);
            rd_chk("R1 mask", e*4 + 2, 0);
        end
        chk("R1 hs_valid", int'(hs_valid), 0);
        chk("R1 irq", int'(irq), 0);
    endtask

    task automatic t_out;
        txn(0, 0, 64, 64, 64, 0, 0);
        chk("R13 hs_valid", int'(hs_valid), 1);
        chk("R4 full OUT ack", int'(hs_code), ACK);
        chk("R6 OUT keep", int'(hs_keep), 1);
        rd_chk("R4 out_ack status", 1, 8'h02);
        rd_chk("R6 toggle flipped", 0, 8'h20);
        @(negedge clk);
        chk("R13 hs_valid single pulse", int'(hs_valid), 0);
        rd_chk("R13 other ep untouched", 5, 0);
        txn(0, 0, 10, 20, 64, 1, 0);
        chk("R4 no room NAK", int'(hs_code), NAK);
        rd_chk("R4 out_nak status", 1, 8'h12);
        rd_chk("R6 NAK keeps toggle", 0, 8'h20);
        txn(0, 0, 64, 8, 64, 1, 0);
        chk("R4 short OUT ack", int'(hs_code), ACK);
        rd_chk("R4 out_short status", 1, 8'h16);
        rd_chk("R6 toggle back", 0, 8'h00);
        txn(0, 0, 64, 64, 64, 1, 0);
        chk("R6 mismatch ack", int'(hs_code), ACK);
        chk("R6 mismatch drop", int'(hs_keep), 0);
        rd_chk("R6 mismatch toggle held", 0, 8'h00);
    endtask

    task automatic t_in;
        txn(1, 1, 100, 0, 64, 0, 0);
        chk("R5 full IN ack", int'(hs_code), ACK);
        chk("R5 full IN len", int'(hs_len), 64);
        chk("R6 IN toggle used", int'(hs_tgl), 0);
        txn(1, 1, 10, 0, 64, 0, 0);
        chk("R5 partial IN NAK", int'(hs_code), NAK);
        rd_chk("R5 in status", 5, 8'h09);
        wr(4, 8'h08);
        txn(1, 1, 10, 0, 64, 0, 0);
        chk("R5 short IN ack", int'(hs_code), ACK);
        chk("R5 short IN len", int'(hs_len), 10);
        chk("R6 IN toggle used 2", int'(hs_tgl), 1);
        rd_chk("R5 short enable cleared", 4, 8'h00);
    endtask

    task automatic t_force;
        wr(8, 8'h01);
        txn(2, 0, 64, 8, 64, 0, 0);
        chk("R3 OUT forced NAK", int'(hs_code), NAK);
        txn(2, 1, 100, 0, 64, 0, 0);
        chk("R3 IN forced NAK", int'(hs_code), NAK);
        rd_chk("R3 nak status", 9, 8'h18);
        wr(8, 8'h03);
        txn(2, 1, 100, 0, 64, 0, 0);
        chk("R2 STALL beats NAK", int'(hs_code), STALL);
        wr(8, 8'h02);
        txn(2, 0, 64, 64, 64, 0, 0);
        chk("R2 OUT STALL", int'(hs_code), STALL);
        rd_chk("R2 no status on stall", 9, 8'h18);
        rd_chk("R2 toggle unchanged", 8, 8'h02);
    endtask

    task automatic t_err;
        txn(2, 0, 64, 64, 64, 0, 1);
        chk("R10 OUT error silent", int'(hs_code), NONE);
        rd_chk("R10 out_err", 9, 8'h58);
        txn(2, 1, 100, 0, 64, 0, 1);
        chk("R10 IN error silent", int'(hs_code), NONE);
        rd_chk("R10 in_err", 9, 8'h78);
        rd_chk("R10 ctrl and toggle held", 8, 8'h02);
    endtask

    task automatic t_toggle;
        wr(12, 8'h40);
        rd_chk("R7 toggle set", 12, 8'h20);
        wr(12, 8'h80);
        rd_chk("R7 toggle clear", 12, 8'h00);
    endtask

    task automatic t_auto;
        wr(12, 8'h04);
        txn(3, 0, 64, 64, 64, 0, 0);
        chk("R8 first OUT ack", int'(hs_code), ACK);
        rd_chk("R8 forced NAK set", 12, 8'h25);
        txn(3, 0, 64, 64, 64, 1, 0);
        chk("R8 next OUT NAK", int'(hs_code), NAK);
        wr(12, 8'h14);
        txn(3, 0, 64, 8, 64, 1, 0);
        chk("R9 short OUT ack", int'(hs_code), ACK);
        rd_chk("R9 no forced NAK", 12, 8'h14);
        txn(3, 0, 64, 64, 64, 0, 0);
        rd_chk("R9 full OUT still forces", 12, 8'h35);
        wr(12, 8'h04);
        txn(3, 0, 64, 8, 64, 1, 0);
        rd_chk("R8 short OUT forces without override", 12, 8'h05);
    endtask

    task automatic t_w1c_irq;
        chk("R12 masked off", int'(irq[0]), 0);
        wr(2, 8'h10);
        #1;
        chk("R12 irq on mask", int'(irq[0]), 1);
        wr(1, 8'h10);
        rd_chk("R11 w1c", 1, 8'h06);
        #1;
        chk("R12 irq off after clear", int'(irq[0]), 0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 8'h02;
        txn_end = 1'b1; txn_ep = 2'd0; txn_in = 1'b0;
        fifo_lvl = 64; pkt_len = 64; max_pkt = 64; pkt_tgl = 1'b0; txn_err = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0; txn_end = 1'b0;
        rd_chk("R11 set beats clear", 1, 8'h06);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_out;
        t_in;
        t_force;
        t_err;
        t_toggle;
        t_auto;
        t_w1c_irq;
        done = 1;
        report;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            report;
        end
    end

endmodule